// File: doc/BRIEF.md
# Shared Virtual-Function Memory Window Decoder

This block holds the single set of memory base registers that every virtual function of one physical function shares, and decodes incoming memory request addresses to the virtual function that owns them. One programmed base address opens a run of equal-size windows, one per enabled virtual function, laid end to end. Window one starts at the base, and each later window starts one window size above the one before it.

Each of the six register slots has a window size fixed at build time. A slot whose size parameter is zero is absent. The size used for decode is the larger of the built-in size and the system page size, so every window starts on a page boundary. Software finds the size in the usual way: it writes all ones to a slot and reads it back, and the bits below the window size read as zero.

Decode works only while both the function-enable input and the memory-space-enable input are high. A request produces a registered result one clock later. The result carries a hit flag, the virtual function number (counting from 1), the slot index and the byte offset inside that function's window.

Top module: `vfbar_decoder`

## Requirements
- R1: A synchronous reset clears every base register to zero and drives `hit`, `hit_vf`, `hit_bar`, `hit_off` and `cfg_rdata` to zero.
- R2: The window size is 2^A bytes, where A is the larger of the slot's built-in size exponent and 12 + `page_shift` (page size = 4096 << `page_shift`). Writing all ones to an implemented slot and reading it back returns ~(2^A - 1).
- R3: A slot whose built-in exponent is 0 (slots 2, 4 and 5 by default) always reads as zero and never produces a hit. A read of a slot index at or above the slot count returns zero.
- R4: Readback of a slot returns the written value with every bit below A forced to zero, and bits 11:0 are always zero. A later change of `page_shift` re-masks the stored value without a rewrite.
- R5: For a base B (with the low A bits cleared), an address in [B + (N-1)*2^A, B + N*2^A) with 1 <= N <= `num_vfs` gives `hit`=1, `hit_vf`=N, `hit_bar`=slot index and `hit_off`=address - (B + (N-1)*2^A).
- R6: An address below B, or at or above B + `num_vfs`*2^A, gives no hit. When `num_vfs`=0, no address hits.
- R7: No hit is produced unless `vf_en` and `vf_mse` were both 1 when the request was taken.
- R8: The result for a request taken at a rising edge appears after that edge. When `req_valid` was 0 at that edge, `hit` is 0 and every result field is zero.
- R9: When windows of several slots cover the same address, the slot with the lowest index wins.
- R10: `cfg_rdata` is registered: it shows the value of the slot selected by `cfg_idx` at the previous rising edge. A write becomes visible to readback and to decode from the edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vf_en | input | 1 | Virtual functions enabled |
| vf_mse | input | 1 | Memory space enable shared by all virtual functions |
| num_vfs | input | VF_W | Number of enabled virtual functions |
| page_shift | input | PS_W | System page size, 4096 << value |
| cfg_we | input | 1 | Base register write strobe |
| cfg_idx | input | $clog2(NUM_BARS) | Slot selected for write and readback |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_rdata | output | ADDR_W | Registered readback of the selected slot |
| req_valid | input | 1 | Memory request present |
| req_addr | input | ADDR_W | Memory request address |
| hit | output | 1 | Request fell in a virtual-function window |
| hit_vf | output | VF_W | Owning virtual function, counted from 1 |
| hit_bar | output | $clog2(NUM_BARS) | Slot that matched |
| hit_off | output | ADDR_W | Byte offset inside the owning window |

## Verification
The decode result for a request is due one rising edge after `req_valid` and `req_addr` are applied. The bench drives each request at a falling edge, computes the expected result from the enables, count and page size present at that moment, and compares at the next falling edge. Readback is due one edge after `cfg_idx` is set and is compared in the same way. Each write is allowed to finish its edge before any read or request uses the new base, so every comparison lands on the first cycle in which the result is defined.

// File: rtl/vfbar_pkg.sv
package vfbar_pkg;
  localparam int unsigned MIN_PAGE_LG = 12;

  // Effective window exponent: larger of fixed slot size and page size.
  function automatic logic [5:0] eff_lg(input logic [5:0] bar_lg, input logic [5:0] pg_lg);
    return (bar_lg > pg_lg) ? bar_lg : pg_lg;
  endfunction
endpackage

// File: rtl/vfbar_regs.sv
module vfbar_regs #(
  parameter int ADDR_W   = 32,
  parameter int NUM_BARS = 6,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [ADDR_W-1:0]          wdata,
  input  logic [NUM_BARS*ADDR_W-1:0] mask_flat,
  output logic [NUM_BARS*ADDR_W-1:0] base_flat,
  output logic [ADDR_W-1:0]          rdata
);
  logic [ADDR_W-1:0] raw    [NUM_BARS];
  logic [ADDR_W-1:0] masked [NUM_BARS];
  logic              idx_ok;

  assign idx_ok = int'(idx) < NUM_BARS;

  for (genvar k = 0; k < NUM_BARS; k++) begin : g_mask
    assign masked[k] = raw[k] & mask_flat[k*ADDR_W +: ADDR_W];
    assign base_flat[k*ADDR_W +: ADDR_W] = masked[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_BARS; k++) raw[k] <= '0;
      rdata <= '0;
    end else begin
      if (we && idx_ok) raw[idx] <= wdata;
      rdata <= idx_ok ? masked[idx] : '0;
    end
  end
endmodule

// File: rtl/vfbar_window.sv
module vfbar_window #(
  parameter int ADDR_W = 32,
  parameter int VF_W   = 8
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [5:0]        ap_lg,
  input  logic [VF_W-1:0]   num_vfs,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [VF_W-1:0]   vf_num,
  output logic [ADDR_W-1:0] off
);
  localparam int WW = ADDR_W + VF_W + 1;

  logic [WW-1:0] a_x, b_x, diff, span;

  assign a_x  = WW'(addr);
  assign b_x  = WW'(base);
  assign diff = a_x - b_x;
  assign span = WW'(num_vfs) << ap_lg;

  assign hit    = en && (a_x >= b_x) && (diff < span);
  assign vf_num = VF_W'((diff >> ap_lg) + WW'(1));
  assign off    = ADDR_W'(diff & ~({WW{1'b1}} << ap_lg));
endmodule

// File: rtl/vfbar_decoder.sv
module vfbar_decoder
  import vfbar_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_BARS = 6,
  parameter int VF_W     = 8,
  parameter int PS_W     = 4,
  parameter logic [NUM_BARS*6-1:0] BAR_LG = {6'd0, 6'd0, 6'd20, 6'd0, 6'd16, 6'd12}
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        vf_en,
  input  logic                        vf_mse,
  input  logic [VF_W-1:0]             num_vfs,
  input  logic [PS_W-1:0]             page_shift,
  input  logic                        cfg_we,
  input  logic [$clog2(NUM_BARS)-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]           cfg_wdata,
  output logic [ADDR_W-1:0]           cfg_rdata,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        hit,
  output logic [VF_W-1:0]             hit_vf,
  output logic [$clog2(NUM_BARS)-1:0] hit_bar,
  output logic [ADDR_W-1:0]           hit_off
);
  localparam int IDX_W = $clog2(NUM_BARS);

  logic [5:0]                 pg_lg;
  logic [NUM_BARS*ADDR_W-1:0] mask_flat;
  logic [NUM_BARS*ADDR_W-1:0] base_flat;
  logic                       dec_en;

  logic              w_hit [NUM_BARS];
  logic [VF_W-1:0]   w_vf  [NUM_BARS];
  logic [ADDR_W-1:0] w_off [NUM_BARS];

  assign pg_lg  = 6'(int'(MIN_PAGE_LG) + int'(page_shift));
  assign dec_en = vf_en && vf_mse;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [5:0] LG_I = BAR_LG[i*6 +: 6];
    logic [5:0] ap_lg;
    if (LG_I != 6'd0) begin : g_impl
      assign ap_lg = eff_lg(LG_I, pg_lg);
      assign mask_flat[i*ADDR_W +: ADDR_W] = {ADDR_W{1'b1}} << ap_lg;
      vfbar_window #(.ADDR_W(ADDR_W), .VF_W(VF_W)) u_win (
        .en     (dec_en),
        .base   (base_flat[i*ADDR_W +: ADDR_W]),
        .ap_lg  (ap_lg),
        .num_vfs(num_vfs),
        .addr   (req_addr),
        .hit    (w_hit[i]),
        .vf_num (w_vf[i]),
        .off    (w_off[i])
      );
    end else begin : g_absent
      assign ap_lg = 6'd0;
      assign mask_flat[i*ADDR_W +: ADDR_W] = '0;
      assign w_hit[i] = 1'b0;
      assign w_vf[i]  = '0;
      assign w_off[i] = '0;
    end
  end

  vfbar_regs #(.ADDR_W(ADDR_W), .NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .mask_flat(mask_flat),
    .base_flat(base_flat),
    .rdata    (cfg_rdata)
  );

  // Lowest slot index takes priority: scan from the top down.
  logic              sel_hit;
  logic [IDX_W-1:0]  sel_bar;
  logic [VF_W-1:0]   sel_vf;
  logic [ADDR_W-1:0] sel_off;

  always_comb begin
    sel_hit = 1'b0;
    sel_bar = '0;
    sel_vf  = '0;
    sel_off = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (w_hit[i]) begin
        sel_hit = 1'b1;
        sel_bar = IDX_W'(i);
        sel_vf  = w_vf[i];
        sel_off = w_off[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit     <= 1'b0;
      hit_vf  <= '0;
      hit_bar <= '0;
      hit_off <= '0;
    end else if (req_valid && sel_hit) begin
      hit     <= 1'b1;
      hit_vf  <= sel_vf;
      hit_bar <= sel_bar;
      hit_off <= sel_off;
    end else begin
      hit     <= 1'b0;
      hit_vf  <= '0;
      hit_bar <= '0;
      hit_off <= '0;
    end
  end
endmodule

// File: rtl/vfbar_decoder_chk.sv
module vfbar_decoder_chk
  import vfbar_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_BARS = 6,
  parameter int VF_W     = 8,
  parameter int PS_W     = 4,
  parameter logic [NUM_BARS*6-1:0] BAR_LG = {6'd0, 6'd0, 6'd20, 6'd0, 6'd16, 6'd12}
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        vf_en,
  input logic                        vf_mse,
  input logic [VF_W-1:0]             num_vfs,
  input logic [PS_W-1:0]             page_shift,
  input logic                        cfg_we,
  input logic [$clog2(NUM_BARS)-1:0] cfg_idx,
  input logic [ADDR_W-1:0]           cfg_wdata,
  input logic [ADDR_W-1:0]           cfg_rdata,
  input logic                        req_valid,
  input logic [ADDR_W-1:0]           req_addr,
  input logic                        hit,
  input logic [VF_W-1:0]             hit_vf,
  input logic [$clog2(NUM_BARS)-1:0] hit_bar,
  input logic [ADDR_W-1:0]           hit_off
);
  function automatic logic [5:0] slot_lg(input int s);
    return (s < NUM_BARS) ? BAR_LG[s*6 +: 6] : 6'd0;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!hit && hit_vf == '0 && hit_off == '0 && cfg_rdata == '0));

  a_r7_enables: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(vf_en) && $past(vf_mse)));

  a_r8_needs_request: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(req_valid));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_vf == '0 && hit_bar == '0 && hit_off == '0));

  a_r6_vf_range: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_vf != '0 && hit_vf <= $past(num_vfs)));

  a_r3_present_slot: assert property (@(posedge clk) disable iff (rst)
    hit |-> (slot_lg(int'(hit_bar)) != 6'd0));

  a_r4_low_bits: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[MIN_PAGE_LG-1:0] == '0);

  a_r5_offset_bound: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((hit_off >> eff_lg(slot_lg(int'(hit_bar)),
                                6'(int'(MIN_PAGE_LG) + int'($past(page_shift))))) == '0));
endmodule

bind vfbar_decoder vfbar_decoder_chk #(
  .ADDR_W(ADDR_W), .NUM_BARS(NUM_BARS), .VF_W(VF_W), .PS_W(PS_W), .BAR_LG(BAR_LG)
) u_chk (.*);

// File: tb/vfbar_decoder_tb.sv
module vfbar_decoder_tb;
  localparam int ADDR_W   = 32;
  localparam int NUM_BARS = 6;
  localparam int VF_W     = 8;
  localparam int PS_W     = 4;
  localparam int IDX_W    = 3;
  localparam logic [NUM_BARS*6-1:0] BAR_LG = {6'd0, 6'd0, 6'd20, 6'd0, 6'd16, 6'd12};

  // Fixed slot exponents as stated in the requirements: 12,16,absent,20,absent,absent.
  int LGS [NUM_BARS] = '{12, 16, 0, 20, 0, 0};

  logic clk = 0;
  always #2 clk = ~clk;

  logic              rst = 1;
  logic              vf_en = 0, vf_mse = 0;
  logic [VF_W-1:0]   num_vfs = 0;
  logic [PS_W-1:0]   page_shift = 0;
  logic              cfg_we = 0;
  logic [IDX_W-1:0]  cfg_idx = 0;
  logic [ADDR_W-1:0] cfg_wdata = 0;
  logic [ADDR_W-1:0] cfg_rdata;
  logic              req_valid = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic              hit;
  logic [VF_W-1:0]   hit_vf;
  logic [IDX_W-1:0]  hit_bar;
  logic [ADDR_W-1:0] hit_off;

  vfbar_decoder #(.ADDR_W(ADDR_W), .NUM_BARS(NUM_BARS), .VF_W(VF_W), .PS_W(PS_W),
                  .BAR_LG(BAR_LG)) u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [ADDR_W-1:0] m_base [NUM_BARS];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int ap_of(input int s);
    int pg = 12 + int'(page_shift);
    if (LGS[s] == 0) return 0;
    return (LGS[s] > pg) ? LGS[s] : pg;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_read(input int s);
    longint m;
    if (s >= NUM_BARS || LGS[s] == 0) return '0;
    m = ~((64'd1 << ap_of(s)) - 1);
    return m_base[s] & ADDR_W'(m);
  endfunction

  task automatic cfg_wr(input int s, input logic [ADDR_W-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IDX_W'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (s < NUM_BARS) m_base[s] = d;
  endtask

  task automatic cfg_rd(input int s, input string req);
    logic [ADDR_W-1:0] e;
    @(negedge clk);
    cfg_idx = IDX_W'(s);
    @(negedge clk);
    e = exp_read(s);
    chk(cfg_rdata == e, req, $sformatf("readback slot %0d", s), cfg_rdata, e);
  endtask

  task automatic req_chk(input logic [ADDR_W-1:0] a, input bit v, input string req);
    bit e_hit = 0; longint e_vf = 0, e_bar = 0, e_off = 0;
    @(negedge clk);
    req_valid = v; req_addr = a;
    if (v && vf_en && vf_mse) begin
      for (int s = NUM_BARS - 1; s >= 0; s--) begin
        longint st, d, ap;
        if (LGS[s] != 0) begin
          ap = 64'd1 << ap_of(s);
          st = longint'(exp_read(s));
          d  = longint'(a) - st;
          if (longint'(a) >= st && d < longint'(num_vfs) * ap) begin
            e_hit = 1; e_bar = s; e_vf = d / ap + 1; e_off = d % ap;
          end
        end
      end
    end
    @(negedge clk);
    req_valid = 0;
    chk(hit == e_hit, req, $sformatf("hit addr=%h", a), hit, e_hit);
    chk(hit_vf == VF_W'(e_vf), req, "vf", hit_vf, e_vf);
    chk(hit_bar == IDX_W'(e_bar), req, "bar", hit_bar, e_bar);
    chk(hit_off == ADDR_W'(e_off), req, "offset", hit_off, e_off);
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int s = 0; s < NUM_BARS; s++) m_base[s] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(hit == 0, "R1", "hit after reset", hit, 0);
    chk(cfg_rdata == 0, "R1", "rdata after reset", cfg_rdata, 0);
    for (int s = 0; s < NUM_BARS; s++) cfg_rd(s, "R1");

    // R2: sizing with all ones
    cfg_wr(0, '1);
    cfg_rd(0, "R2");
    chk(cfg_rdata == 32'hFFFF_F000, "R2", "slot0 size ps0", cfg_rdata, 32'hFFFF_F000);
    cfg_wr(3, '1);
    cfg_rd(3, "R2");
    chk(cfg_rdata == 32'hFFF0_0000, "R2", "slot3 size", cfg_rdata, 32'hFFF0_0000);
    page_shift = 5;
    cfg_rd(0, "R4");
    chk(cfg_rdata == 32'hFFFE_0000, "R4", "slot0 remask ps5", cfg_rdata, 32'hFFFE_0000);
    page_shift = 0;
    // R3: absent slots and out-of-range index
    cfg_wr(2, '1);
    cfg_rd(2, "R3");
    cfg_rd(7, "R3");
    // R4: low bits dropped
    cfg_wr(0, 32'h1000_0ABC);
    cfg_rd(0, "R4");
    cfg_wr(1, 32'h4000_1234);
    cfg_rd(1, "R4");
    cfg_wr(3, 32'h8000_0000);
    cfg_rd(3, "R10");

    // R7: enables gate decode
    num_vfs = 5;
    req_chk(32'h1000_0000, 1, "R7");
    vf_en = 1;
    req_chk(32'h1000_0000, 1, "R7");
    vf_en = 0; vf_mse = 1;
    req_chk(32'h1000_0000, 1, "R7");
    vf_en = 1;
    // R5: window boundaries
    req_chk(32'h1000_0000, 1, "R5");
    req_chk(32'h1000_4010, 1, "R5");
    req_chk(32'h1000_4FFF, 1, "R5");
    req_chk(32'h4000_FFFF, 1, "R5");
    req_chk(32'h8030_0007, 1, "R5");
    // R6: outside the run
    req_chk(32'h1000_5000, 1, "R6");
    req_chk(32'h0FFF_FFFF, 1, "R6");
    num_vfs = 0;
    req_chk(32'h1000_0000, 1, "R6");
    num_vfs = 5;
    // R8: no request, no hit
    req_chk(32'h1000_0000, 0, "R8");
    // R9: overlapping slots, lowest wins
    cfg_wr(1, 32'h1000_0000);
    req_chk(32'h1000_0040, 1, "R9");
    req_chk(32'h1000_8000, 1, "R9");
    // R2 with larger page: stride grows
    page_shift = 4;
    req_chk(32'h1001_0000, 1, "R2");
    page_shift = 0;

    // Random mix
    for (int it = 0; it < 1500; it++) begin
      int s; longint ap, a; int k;
      if ($urandom_range(0, 15) == 0) begin
        vf_en = ($urandom_range(0, 7) != 0);
        vf_mse = ($urandom_range(0, 7) != 0);
        num_vfs = VF_W'($urandom_range(0, 40));
        page_shift = PS_W'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 63) == 0)
        cfg_wr($urandom_range(0, 5), {4'($urandom_range(0, 15)), 28'($urandom)});
      case ($urandom_range(0, 3))
        0: s = 0; 1: s = 1; 2: s = 3; default: s = 2;
      endcase
      if (LGS[s] == 0) s = 0;
      ap = 64'd1 << ap_of(s);
      k = $urandom_range(0, int'(num_vfs) + 1);
      a = longint'(exp_read(s)) + longint'(k) * ap + (longint'($urandom) % ap);
      if ($urandom_range(0, 9) == 0) a = longint'(exp_read(s)) - 1;
      req_chk(ADDR_W'(a), ($urandom_range(0, 9) != 0), "R5");
    end
    done = 1;
    report();
  end
endmodule